// File: doc/BRIEF.md
# Multi-Candidate Wildcard Key Comparator

This block checks one dictionary key of NPOS characters against a window of text candidates. The key is read in parallel from per-position character memories. The window holds NLVL candidate levels at each of the NPOS positions. Candidate levels arise when an upstream recognizer is unsure of a character and offers several alternatives for the same text position. The block has no addressing, no window shifting and no dictionary storage. Those belong to the surrounding engine, which presents a new key every few cycles and pulses a compare strobe.

A key position is accepted in either of two cases. The first is that some enabled candidate level at that position holds exactly the key character. The second is that the key character is the reserved padding code. Keys shorter than NPOS are filled with the padding code, so the padding code acts as a wildcard. A key is detected only when every position is accepted. The per-position acceptance vector and the detection flag are both captured in registers on the strobe. A one-cycle valid pulse marks each new result.

Top module: `kc_key_cmp`

## Requirements
- R1: After reset, `pos_match` is all zeros, and `hit` and `hit_vld` are 0.
- R2: `pos_match[p]` is 1 when the key character at position p equals the candidate at position p of any level l whose `lvl_valid[l]` bit is 1. The key character for position p sits at `key_chars[p*CW +: CW]`. The candidate for level l at position p sits at `cand_win[(l*NPOS+p)*CW +: CW]`.
- R3: A key character equal to PAD (default 16'hFFFF) sets its `pos_match` bit. This holds whatever the candidates are, including when every level is masked.
- R4: A candidate on a level whose `lvl_valid` bit is 0 never causes a match, even when it equals the key character.
- R5: `hit` is 1 exactly when all NPOS bits of the captured `pos_match` are 1.
- R6: A single rejected position clears its own `pos_match` bit and forces `hit` to 0, even when all other positions match.
- R7: Results register on the clock edge where `cmp_strobe` is 1. `hit_vld` is 1 for exactly the following cycle of each strobe, so back-to-back strobes give back-to-back results. Without a strobe, `pos_match` and `hit` hold their values.
- R8: With only `lvl_valid[0]` set, each non-PAD key position reduces to an equality compare against level 0 alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_strobe | input | 1 | Capture a comparison result on this edge |
| key_chars | input | NPOS*CW | Key characters, position p at bits p*CW |
| cand_win | input | NLVL*NPOS*CW | Candidate window, level l position p at bits (l*NPOS+p)*CW |
| lvl_valid | input | NLVL | Per-level enable mask |
| pos_match | output | NPOS | Registered per-position acceptance |
| hit | output | 1 | Registered all-positions-accepted flag |
| hit_vld | output | 1 | One-cycle pulse after each strobe |

## Verification
The assertions check on every cycle that the following hold:
- a masked level never reports a lane match;
- a padding key character always lands as an accepted bit;
- `hit` agrees with the captured vector;
- the valid pulse tracks the strobe one cycle later;
- outputs stay frozen between strobes;
- the single-level case is a plain equality.

Some behaviours need the bench's scenarios:
- a match carried only by a lower-priority level;
- the same match vanishing once that level is masked;
- short keys padded over arbitrary candidates;
- a lone mismatch at the last position;
- back-to-back strobes;
- a randomized mix scored against an independent model.

// File: rtl/kc_pkg.sv
package kc_pkg;

  // Bit offset of one candidate inside the flattened window.
  function automatic int unsigned win_base(input int unsigned lvl,
                                           input int unsigned pos,
                                           input int unsigned npos,
                                           input int unsigned cw);
    return (lvl * npos + pos) * cw;
  endfunction

  // Bit offset of one key character inside the flattened key.
  function automatic int unsigned key_base(input int unsigned pos,
                                           input int unsigned cw);
    return pos * cw;
  endfunction

endpackage

// File: rtl/kc_lane_eq.sv
// One candidate level at one position: an equality gated by the level enable.
module kc_lane_eq #(
  parameter int unsigned CW = 16
) (
  input  logic [CW-1:0] key_chr,
  input  logic [CW-1:0] cand_chr,
  input  logic          lvl_en,
  output logic          eq
);
  always_comb eq = lvl_en && (key_chr == cand_chr);
endmodule

// File: rtl/kc_pos_cmp.sv
// One key position: OR of all enabled levels, plus the padding wildcard.
module kc_pos_cmp #(
  parameter int unsigned CW   = 16,
  parameter int unsigned NLVL = 3,
  parameter logic [CW-1:0] PAD = '1
) (
  input  logic [CW-1:0]      key_chr,
  input  logic [NLVL*CW-1:0] cand_col,
  input  logic [NLVL-1:0]    lvl_valid,
  output logic [NLVL-1:0]    lane_hit,
  output logic               pos_hit
);
  logic key_is_pad;

  for (genvar l = 0; l < NLVL; l++) begin : g_lane
    kc_lane_eq #(.CW(CW)) i_lane (
      .key_chr (key_chr),
      .cand_chr(cand_col[l*CW +: CW]),
      .lvl_en  (lvl_valid[l]),
      .eq      (lane_hit[l])
    );
  end

  always_comb begin
    key_is_pad = (key_chr == PAD);
    pos_hit    = key_is_pad | (|lane_hit);
  end
endmodule

// File: rtl/kc_result_reg.sv
// Captures the acceptance vector and the all-accepted flag on the strobe.
module kc_result_reg #(
  parameter int unsigned NPOS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            strobe,
  input  logic [NPOS-1:0] pos_vec,
  output logic [NPOS-1:0] pos_q,
  output logic            hit_q,
  output logic            vld_q
);
  function automatic logic all_ones(input logic [NPOS-1:0] v);
    logic r;
    r = 1'b1;
    for (int i = 0; i < NPOS; i++) r = r & v[i];
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      hit_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= strobe;
      if (strobe) begin
        pos_q <= pos_vec;
        hit_q <= all_ones(pos_vec);
      end
    end
  end

  AST_HIT_IS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q == (pos_q == {NPOS{1'b1}})); // R5
  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> vld_q); // R7
  AST_VLD_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> !vld_q); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> ($stable(pos_q) && $stable(hit_q))); // R7
endmodule

// File: rtl/kc_key_cmp.sv
module kc_key_cmp
  import kc_pkg::*;
#(
  parameter int unsigned   NPOS = 8,
  parameter int unsigned   NLVL = 3,
  parameter int unsigned   CW   = 16,
  parameter logic [CW-1:0] PAD  = 16'hFFFF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmp_strobe,
  input  logic [NPOS*CW-1:0]     key_chars,
  input  logic [NLVL*NPOS*CW-1:0] cand_win,
  input  logic [NLVL-1:0]        lvl_valid,
  output logic [NPOS-1:0]        pos_match,
  output logic                   hit,
  output logic                   hit_vld
);
  localparam int unsigned COLW = NLVL * CW;

  logic [COLW-1:0]  cand_col [NPOS];
  logic [NLVL-1:0]  lane_hit [NPOS];
  logic [NPOS-1:0]  pos_now;

  for (genvar p = 0; p < NPOS; p++) begin : g_pos
    for (genvar l = 0; l < NLVL; l++) begin : g_gather
      assign cand_col[p][l*CW +: CW] = cand_win[win_base(l, p, NPOS, CW) +: CW];
    end

    kc_pos_cmp #(.CW(CW), .NLVL(NLVL), .PAD(PAD)) i_pos (
      .key_chr  (key_chars[key_base(p, CW) +: CW]),
      .cand_col (cand_col[p]),
      .lvl_valid(lvl_valid),
      .lane_hit (lane_hit[p]),
      .pos_hit  (pos_now[p])
    );

    AST_MASKED_LANE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_hit[p] & ~lvl_valid) == '0); // R4
    AST_PAD_ACCEPTS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_strobe && key_chars[p*CW +: CW] == PAD) |=> pos_match[p]); // R3
    AST_SINGLE_LEVEL_EQ: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_strobe && lvl_valid == NLVL'(1) && key_chars[p*CW +: CW] != PAD)
      |=> (pos_match[p] == ($past(key_chars[p*CW +: CW]) == $past(cand_win[p*CW +: CW])))); // R8
  end

  kc_result_reg #(.NPOS(NPOS)) i_res (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (cmp_strobe),
    .pos_vec(pos_now),
    .pos_q  (pos_match),
    .hit_q  (hit),
    .vld_q  (hit_vld)
  );
endmodule

// File: tb/test_kc_key_cmp.sv
`timescale 1ns/1ps
module test_kc_key_cmp;
  localparam int NPOS = 8;
  localparam int NLVL = 3;
  localparam int CW   = 16;
  localparam logic [15:0] PADC = 16'hFFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp_strobe = 1'b0;
  logic [NPOS*CW-1:0] key_chars = '0;
  logic [NLVL*NPOS*CW-1:0] cand_win = '0;
  logic [NLVL-1:0] lvl_valid = '0;
  logic [NPOS-1:0] pos_match;
  logic hit, hit_vld;

  always #4 clk = ~clk;

  kc_key_cmp i_kc_key_cmp (
    .clk(clk), .rst_n(rst_n), .cmp_strobe(cmp_strobe), .key_chars(key_chars),
    .cand_win(cand_win), .lvl_valid(lvl_valid), .pos_match(pos_match),
    .hit(hit), .hit_vld(hit_vld)
  );

  int checks = 0;
  int errs = 0;
  logic [15:0] bkey [NPOS];
  logic [15:0] bwin [NLVL][NPOS];
  logic [NPOS-1:0] exp_pm_q [$];
  logic            exp_h_q  [$];
  string           tag_q    [$];

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Independent model: a position passes if padded, or if any enabled level holds the char.
  function automatic logic [NPOS-1:0] model(input logic [NLVL-1:0] v);
    logic [NPOS-1:0] r;
    for (int p = 0; p < NPOS; p++) begin
      r[p] = (bkey[p] == PADC);
      for (int l = 0; l < NLVL; l++)
        if (v[l] && bwin[l][p] == bkey[p]) r[p] = 1'b1;
    end
    return r;
  endfunction

  task automatic fire(input logic [NLVL-1:0] v, input string tag);
    logic [NPOS-1:0] e;
    @(negedge clk);
    for (int p = 0; p < NPOS; p++) begin
      key_chars[p*CW +: CW] = bkey[p];
      for (int l = 0; l < NLVL; l++) cand_win[(l*NPOS+p)*CW +: CW] = bwin[l][p];
    end
    lvl_valid = v;
    cmp_strobe = 1'b1;
    e = model(v);
    exp_pm_q.push_back(e);
    exp_h_q.push_back(e == '1);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmp_strobe = 1'b0;
    end
  endtask

  task automatic fill(input logic [15:0] base);
    for (int p = 0; p < NPOS; p++) begin
      bkey[p] = base + 16'(p);
      for (int l = 0; l < NLVL; l++) bwin[l][p] = 16'h0100 + 16'(l*16 + p);
    end
  endtask

  // Monitor: pops one expected result per valid pulse.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && hit_vld) begin
        if (exp_pm_q.size() == 0) begin
          check("R7", "unexpected hit_vld", 1, 0);
        end else begin
          string t;
          logic [NPOS-1:0] epm;
          logic eh;
          t = tag_q.pop_front();
          epm = exp_pm_q.pop_front();
          eh = exp_h_q.pop_front();
          check(t, "pos_match", 32'(pos_match), 32'(epm));
          check("R5", "hit", 32'(hit), 32'(eh));
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errs++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [NPOS-1:0] hold_pm;
    logic hold_h;
    repeat (3) @(negedge clk);
    check("R1", "reset pos_match", 32'(pos_match), 0);
    check("R1", "reset hit", 32'(hit), 0);
    check("R1", "reset hit_vld", 32'(hit_vld), 0);
    rst_n = 1'b1;
    idle(2);

    // R8: one level, exact copy of the key
    fill(16'h0040);
    for (int p = 0; p < NPOS; p++) bwin[0][p] = bkey[p];
    fire(3'b001, "R8");
    idle(2);

    // R2: position 3 matched only by level 1
    fill(16'h0040);
    for (int p = 0; p < NPOS; p++) bwin[0][p] = bkey[p];
    bwin[0][3] = 16'h0777;
    bwin[1][3] = bkey[3];
    fire(3'b011, "R2");
    // R4: same window, level 1 masked -> position 3 rejected
    fire(3'b101, "R4");
    idle(2);

    // R3: short key padded over unrelated candidates
    fill(16'h0200);
    for (int p = 0; p < 5; p++) bwin[2][p] = bkey[p];
    for (int p = 5; p < NPOS; p++) bkey[p] = PADC;
    fire(3'b100, "R3");
    // R3: all pads, every level masked
    for (int p = 0; p < NPOS; p++) bkey[p] = PADC;
    fire(3'b000, "R3");
    idle(2);

    // R6: lone mismatch at the last position
    fill(16'h0300);
    for (int p = 0; p < NPOS; p++) bwin[1][p] = bkey[p];
    bwin[1][NPOS-1] = 16'h0001;
    fire(3'b010, "R6");
    idle(2);

    // R7: outputs hold without a strobe
    hold_pm = pos_match;
    hold_h = hit;
    idle(3);
    check("R7", "hold pos_match", 32'(pos_match), 32'(hold_pm));
    check("R7", "hold hit", 32'(hit), 32'(hold_h));
    check("R7", "no pulse while idle", 32'(hit_vld), 0);

    // R2: randomized mix over a small alphabet, back-to-back strobes
    for (int n = 0; n < 60; n++) begin
      for (int p = 0; p < NPOS; p++) begin
        bkey[p] = ($urandom % 8 == 0) ? PADC : 16'($urandom % 3);
        for (int l = 0; l < NLVL; l++) bwin[l][p] = 16'($urandom % 3);
      end
      fire(3'($urandom % 8), "R2");
    end
    idle(4);
    check("R7", "all results drained", 32'(exp_pm_q.size()), 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule